// File: doc/BRIEF.md
# Prioritized interrupt source encoder

This block gathers the event pulses of a serial bus controller into a set of sticky status flags. It gates each flag with its own enable bit. It then holds a 4-bit code that names the most urgent pending, enabled event. The interrupt output is raised whenever that code is nonzero.

Software services the interrupt by reading the code register. A normal read returns the code and consumes it in the same access. On that clock the block loads the next less urgent source that is still eligible, or zero when there is none. For three of the sources, the read also clears the matching flag. A read marked as a debug access shows the same value but changes nothing.

A source whose code has been consumed stays quiet until its event fires again. Because of this, a flag that software leaves set cannot raise the interrupt over and over. A module soft-reset input returns the flags and the code to their reset state.

Top module: `irqenc_top`

## Requirements
- R1: Status bit i (i = 0..7) belongs to the source with code i+1. Code 1 is arbitration lost (most urgent), then 2 NACK, 3 registers ready, 4 receive ready, 5 transmit ready, 6 stop seen, 7 addressed as target, and 8 clock stretch (least urgent). Code 0 means no source. While the code is zero, the lowest eligible code is loaded on the clock after its flag becomes visible.
- R2: The enable register (address 1, bits 7:0, bit i for source i) resets to 0. A source whose enable bit is 0 never produces a code or an interrupt.
- R3: A non-debug read of the code register (address 2, bits 3:0) returns the held code. On that clock the register loads the lowest eligible code greater than the one read, or 0 if there is none.
- R4: A non-debug read that returns code 1, 2 or 6 also clears status bit 0, 1 or 5 respectively.
- R5: A read with the debug qualifier high leaves the code, the flags and the interrupt unchanged.
- R6: A write to the status register (address 0) clears every flag whose data bit is 1, except bit 4. Data bits that are 0 have no effect, and bit 4 ignores writes.
- R7: Status bit 4 (transmit ready) resets to 1, is set by its event, and is cleared by the transmit-data-write input.
- R8: The interrupt output is high exactly when the code is nonzero. A held code is not replaced by any new event until it is read.
- R9: When a flag is set and cleared in the same clock, it ends up set.
- R10: A soft-reset pulse returns all flags to their reset values (only bit 4 set) and the code to 0, and leaves the enables unchanged.
- R11: Once a source's code has been read, that source is not reported again until its event input pulses anew, even if its flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softRst | input | 1 | Synchronous module soft reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regDbg | input | 1 | Marks the read as a debug access with no side effects |
| regAddr | input | 2 | Register address: 0 status, 1 enable, 2 code |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data, valid in the cycle of the read strobe |
| evtPulse | input | 8 | One-clock event pulses, bit i sets status bit i |
| txWrite | input | 1 | Transmit data was written; clears transmit ready |
| irqOut | output | 1 | Interrupt request |

## Verification
A wrong code register, or a wrong per-source "already served" state, shows on irqOut one clock after the event or read that should have moved it. A reference model compares that pin on every cycle. A missing side clear, or a flag that loses a same-cycle race, shows in the very next read of the status register. A wrong advance order shows in the value returned by the next non-debug code read. The scenarios chain reads across several pending sources, so that a wrong ordering cannot stay hidden.

// File: rtl/irqenc_pkg.sv
package irqenc_pkg;

  // strobes handed from the register decoder to the datapath
  typedef struct packed {
    logic wrStatus;
    logic wrEnable;
    logic rdCodeCpu;
    logic softClr;
  } irqenc_strobe_t;

  localparam int ADDR_STATUS = 0;
  localparam int ADDR_ENABLE = 1;
  localparam int ADDR_CODE   = 2;

endpackage

// File: rtl/irqenc_scan.sv
// Finds the lowest-index eligible source at or above a start index and
// returns its code (index + 1); zero when none qualifies.
module irqenc_scan #(
  parameter int NUM_SRC = 8,
  parameter int CODE_W  = 4
) (
  input  logic [NUM_SRC-1:0] elig,
  input  logic [CODE_W-1:0]  startCode,
  output logic [CODE_W-1:0]  foundCode
);

  logic [NUM_SRC-1:0] inRange;

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : gRange
      assign inRange[g] = elig[g] && (g >= int'(startCode));
    end
  endgenerate

  always_comb begin
    foundCode = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (inRange[k]) foundCode = CODE_W'(k + 1);
    end
  end

endmodule

// File: rtl/irqenc_ctrl.sv
// Register decode and read multiplexer.
module irqenc_ctrl
  import irqenc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 2,
  parameter int CODE_W  = 4
) (
  input  logic                 softRst,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic                 regDbg,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [NUM_SRC-1:0]   flagQ,
  input  logic [NUM_SRC-1:0]   enQ,
  input  logic [CODE_W-1:0]    codeQ,
  output irqenc_strobe_t       strb,
  output logic [DATA_W-1:0]    regRdData
);

  logic selStatus, selEnable, selCode;

  always_comb begin
    selStatus = (regAddr == ADDR_W'(ADDR_STATUS));
    selEnable = (regAddr == ADDR_W'(ADDR_ENABLE));
    selCode   = (regAddr == ADDR_W'(ADDR_CODE));
  end

  always_comb begin
    strb.softClr   = softRst;
    strb.wrStatus  = regWrEn && selStatus;
    strb.wrEnable  = regWrEn && selEnable;
    strb.rdCodeCpu = regRdEn && !regDbg && selCode;
  end

  always_comb begin
    regRdData = '0;
    if (selStatus)      regRdData = DATA_W'(flagQ);
    else if (selEnable) regRdData = DATA_W'(enQ);
    else if (selCode)   regRdData = DATA_W'(codeQ);
  end

endmodule

// File: rtl/irqenc_datapath.sv
// Flags, enables, served marks and the held code.
module irqenc_datapath
  import irqenc_pkg::*;
#(
  parameter int                 NUM_SRC   = 8,
  parameter int                 DATA_W    = 16,
  parameter int                 CODE_W    = 4,
  parameter int                 TX_IDX    = 4,
  parameter logic [NUM_SRC-1:0] W1C_MASK  = 8'b1110_1111,
  parameter logic [NUM_SRC-1:0] SIDE_MASK = 8'b0010_0011,
  parameter logic [NUM_SRC-1:0] RST_MASK  = 8'b0001_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  irqenc_strobe_t       strb,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic [NUM_SRC-1:0]   evtPulse,
  input  logic                 txWrite,
  output logic [NUM_SRC-1:0]   flagQ,
  output logic [NUM_SRC-1:0]   enQ,
  output logic [CODE_W-1:0]    codeQ
);

  logic [NUM_SRC-1:0] servedQ;
  logic [NUM_SRC-1:0] clrHit;
  logic [NUM_SRC-1:0] readHit;
  logic [NUM_SRC-1:0] elig;
  logic [CODE_W-1:0]  scanCode;
  logic [CODE_W-1:0]  codeNext;

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
      localparam logic IS_TX = (g == TX_IDX);

      always_comb begin
        readHit[g] = strb.rdCodeCpu && (codeQ == CODE_W'(g + 1));
        clrHit[g]  = (W1C_MASK[g] && strb.wrStatus && regWrData[g])
                   || (SIDE_MASK[g] && readHit[g])
                   || (IS_TX && txWrite);
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          flagQ[g]   <= RST_MASK[g];
          servedQ[g] <= 1'b0;
        end else if (strb.softClr) begin
          flagQ[g]   <= RST_MASK[g];
          servedQ[g] <= 1'b0;
        end else begin
          if (evtPulse[g])     flagQ[g] <= 1'b1;
          else if (clrHit[g])  flagQ[g] <= 1'b0;

          if (evtPulse[g])     servedQ[g] <= 1'b0;
          else if (readHit[g]) servedQ[g] <= 1'b1;
          else                 servedQ[g] <= servedQ[g] && flagQ[g];
        end
      end

      assign elig[g] = flagQ[g] && enQ[g] && !servedQ[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              enQ <= '0;
    else if (strb.wrEnable) enQ <= regWrData[NUM_SRC-1:0];
  end

  irqenc_scan #(
    .NUM_SRC (NUM_SRC),
    .CODE_W  (CODE_W)
  ) uScan (
    .elig      (elig),
    .startCode (codeQ),
    .foundCode (scanCode)
  );

  always_comb begin
    codeNext = codeQ;
    if (strb.rdCodeCpu || codeQ == '0) codeNext = scanCode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             codeQ <= '0;
    else if (strb.softClr) codeQ <= '0;
    else                   codeQ <= codeNext;
  end

endmodule

// File: rtl/irqenc_top.sv
module irqenc_top
  import irqenc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 2,
  parameter int TX_IDX  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               softRst,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic               regDbg,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic               txWrite,
  output logic               irqOut
);

  localparam int CODE_W = $clog2(NUM_SRC + 1);

  irqenc_strobe_t     strb;
  logic [NUM_SRC-1:0] flagQ;
  logic [NUM_SRC-1:0] enQ;
  logic [CODE_W-1:0]  codeQ;

  irqenc_ctrl #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .CODE_W  (CODE_W)
  ) uCtrl (
    .softRst   (softRst),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regDbg    (regDbg),
    .regAddr   (regAddr),
    .flagQ     (flagQ),
    .enQ       (enQ),
    .codeQ     (codeQ),
    .strb      (strb),
    .regRdData (regRdData)
  );

  irqenc_datapath #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .CODE_W  (CODE_W),
    .TX_IDX  (TX_IDX)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regWrData (regWrData),
    .evtPulse  (evtPulse),
    .txWrite   (txWrite),
    .flagQ     (flagQ),
    .enQ       (enQ),
    .codeQ     (codeQ)
  );

  assign irqOut = (codeQ != '0);

endmodule

// File: rtl/irqenc_checker.sv
module irqenc_checker #(
  parameter int                 NUM_SRC  = 8,
  parameter int                 ADDR_W   = 2,
  parameter int                 DATA_W   = 16,
  parameter int                 CODE_W   = 4,
  parameter int                 TX_IDX   = 4,
  parameter logic [NUM_SRC-1:0] RST_MASK = 8'b0001_0000
) (
  input logic               clk,
  input logic               rstN,
  input logic               softRst,
  input logic               regWrEn,
  input logic               regRdEn,
  input logic               regDbg,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regWrData,
  input logic [NUM_SRC-1:0] evtPulse,
  input logic               txWrite,
  input logic [NUM_SRC-1:0] flagQ,
  input logic [CODE_W-1:0]  codeQ
);

  logic rdCpu, rdDbgCode, wrZeroStatus;
  assign rdCpu        = regRdEn && !regDbg && regAddr == ADDR_W'(2);
  assign rdDbgCode    = regRdEn && regDbg && regAddr == ADDR_W'(2);
  assign wrZeroStatus = regWrEn && regAddr == ADDR_W'(0)
                        && regWrData[NUM_SRC-1:0] == '0;

  assert_code_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    codeQ <= CODE_W'(NUM_SRC));

  assert_read_advance_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdCpu && codeQ != '0 && !softRst |=> (codeQ == '0 || codeQ > $past(codeQ)));

  assert_side_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdCpu && codeQ == CODE_W'(1) && !evtPulse[0] && !softRst |=> !flagQ[0]);

  assert_dbg_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdDbgCode && !regWrEn && !softRst && codeQ != '0 |=> $stable(codeQ));

  assert_write_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrZeroStatus && !rdCpu && !txWrite && !softRst
      |=> (flagQ & $past(flagQ)) == $past(flagQ));

  assert_tx_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    txWrite && !evtPulse[TX_IDX] && !softRst |=> !flagQ[TX_IDX]);

  assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    codeQ != '0 && !rdCpu && !softRst |=> $stable(codeQ));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    !softRst |=> (flagQ & $past(evtPulse)) == $past(evtPulse));

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> codeQ == '0 && flagQ == RST_MASK);

endmodule

bind irqenc_top irqenc_checker #(
  .NUM_SRC (NUM_SRC),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .CODE_W  (CODE_W),
  .TX_IDX  (TX_IDX)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .softRst   (softRst),
  .regWrEn   (regWrEn),
  .regRdEn   (regRdEn),
  .regDbg    (regDbg),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .evtPulse  (evtPulse),
  .txWrite   (txWrite),
  .flagQ     (flagQ),
  .codeQ     (codeQ)
);

// File: tb/sim_irqenc_top.sv
`timescale 1ns/1ps
module sim_irqenc_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softRst = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic        regDbg = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWrData = 16'd0;
  logic [15:0] regRdData;
  logic [7:0]  evtPulse = 8'd0;
  logic        txWrite = 1'b0;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irqenc_top u0 (
    .clk(clk), .rstN(rstN), .softRst(softRst),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regDbg(regDbg),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .evtPulse(evtPulse), .txWrite(txWrite), .irqOut(irqOut)
  );

  // behavioural reference: per-source state, code as an integer
  bit mFlag[8];
  bit mEn[8];
  bit mServed[8];
  int mCode;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) begin
        mFlag[i] = (i == 4); mEn[i] = 0; mServed[i] = 0;
      end
      mCode = 0;
    end else begin
      bit nF[8]; bit nS[8]; bit nE[8]; int nC;
      bit rd;
      rd = regRdEn && !regDbg && regAddr == 2;
      nC = mCode;
      if (rd || mCode == 0) begin
        nC = 0;
        for (int i = 7; i >= 0; i--)
          if (i >= mCode && mFlag[i] && mEn[i] && !mServed[i]) nC = i + 1;
      end
      for (int i = 0; i < 8; i++) begin
        bit clr;
        clr = (regWrEn && regAddr == 0 && regWrData[i] && i != 4)
           || (rd && mCode == i + 1 && (i == 0 || i == 1 || i == 5))
           || (i == 4 && txWrite);
        nF[i] = evtPulse[i] ? 1'b1 : (clr ? 1'b0 : mFlag[i]);
        nS[i] = evtPulse[i] ? 1'b0 : ((rd && mCode == i + 1) ? 1'b1 : (mServed[i] && mFlag[i]));
        nE[i] = (regWrEn && regAddr == 1) ? regWrData[i] : mEn[i];
      end
      if (softRst) begin
        for (int i = 0; i < 8; i++) begin nF[i] = (i == 4); nS[i] = 0; end
        nC = 0;
      end
      mFlag = nF; mServed = nS; mEn = nE; mCode = nC;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=0x%0h exp=0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  // per-clock comparison of the interrupt pin with the model
  always @(negedge clk) begin
    if (rstN && !done) check("R8 irq vs model", int'(irqOut), int'(mCode != 0));
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic doRead(input string req, input int addr, input bit dbg, input int exp);
    regAddr = 2'(addr); regRdEn = 1; regDbg = dbg;
    #1 check(req, int'(regRdData), exp);
    @(negedge clk);
    regRdEn = 0; regDbg = 0;
  endtask

  task automatic doWrite(input int addr, input int data);
    regAddr = 2'(addr); regWrData = 16'(data); regWrEn = 1;
    @(negedge clk);
    regWrEn = 0; regWrData = 0;
  endtask

  task automatic pulse(input int bits);
    evtPulse = 8'(bits);
    @(negedge clk);
    evtPulse = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    rstN = 1;
    idle(1);
    // reset state
    doRead("R7 status reset", 0, 0, 16'h0010);
    doRead("R2 enable reset", 1, 0, 0);
    doRead("R1 code reset", 2, 1, 0);
    check("R8 irq reset", int'(irqOut), 0);

    // transmit ready pending from reset becomes code 5
    doWrite(1, 16'h00FF);
    idle(3);
    doRead("R1 code 5 from tx ready", 2, 0, 5);
    idle(2);
    doRead("R11 served source silent", 2, 0, 0);

    // ordered service of three sources
    pulse(8'b0010_0101);
    idle(2);
    doRead("R1 highest first", 2, 0, 1);
    doRead("R3 advance to 3", 2, 0, 3);
    doRead("R3 advance to 6", 2, 0, 6);
    idle(2);
    doRead("R4 side clears bits 0,5", 0, 0, 16'h0014);
    doRead("R3 none left", 2, 0, 0);

    // write-one-to-clear
    doWrite(0, 16'h0000);
    doRead("R6 zero write no effect", 0, 0, 16'h0014);
    doWrite(0, 16'h0014);
    doRead("R6 clear bit2 keep bit4", 0, 0, 16'h0010);

    // debug read has no side effect
    pulse(8'b0000_0010);
    idle(2);
    doRead("R5 dbg read sees 2", 2, 1, 2);
    idle(1);
    doRead("R5 flag kept", 0, 0, 16'h0012);
    doRead("R5 code kept", 2, 1, 2);
    doRead("R4 cpu read 2", 2, 0, 2);
    idle(1);
    doRead("R4 nack cleared", 0, 0, 16'h0010);

    // held code not replaced
    pulse(8'b0100_0000);
    idle(2);
    pulse(8'b0000_0001);
    idle(2);
    doRead("R8 held code 7", 2, 1, 7);
    doRead("R8 read held 7", 2, 0, 7);
    idle(1);
    doRead("R1 then code 1", 2, 0, 1);
    idle(1);
    doRead("R11 status after", 0, 0, 16'h0050);

    // set beats clear
    regAddr = 0; regWrData = 16'h0040; regWrEn = 1; evtPulse = 8'b0100_0000;
    @(negedge clk);
    regWrEn = 0; regWrData = 0; evtPulse = 0;
    doRead("R9 w1c vs event", 0, 0, 16'h0050);
    idle(1);
    doRead("R11 re-armed by event", 2, 0, 7);
    txWrite = 1; evtPulse = 8'b0001_0000;
    @(negedge clk);
    txWrite = 0; evtPulse = 0;
    doRead("R9 tx write vs event", 0, 0, 16'h0050);
    idle(1);
    doRead("R7 tx ready code 5", 2, 0, 5);
    txWrite = 1;
    @(negedge clk);
    txWrite = 0;
    doRead("R7 tx write clears", 0, 0, 16'h0040);
    doWrite(0, 16'h0040);
    doRead("R6 bit6 cleared", 0, 0, 0);

    // masking
    doWrite(1, 0);
    pulse(8'b0000_1000);
    idle(2);
    check("R2 masked no irq", int'(irqOut), 0);
    doRead("R2 masked code 0", 2, 1, 0);
    doRead("R2 flag still set", 0, 0, 16'h0008);
    doWrite(1, 16'h0008);
    idle(2);
    doRead("R2 enabled code 4", 2, 0, 4);
    idle(1);
    doRead("R3 rx flag not side cleared", 0, 0, 16'h0008);
    doRead("R11 no repeat of 4", 2, 0, 0);

    // soft reset
    doWrite(1, 16'h00FF);
    pulse(8'b0000_0001);
    idle(2);
    check("R10 code 1 before", int'(irqOut), 1);
    softRst = 1;
    @(negedge clk);
    softRst = 0;
    check("R10 irq cleared", int'(irqOut), 0);
    doRead("R10 code cleared", 2, 1, 0);
    doRead("R10 flags reset", 0, 0, 16'h0010);
    doRead("R10 enables kept", 1, 0, 16'h00FF);
    doRead("R10 tx ready reported", 2, 0, 5);
    idle(3);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule